// File: doc/BRIEF.md
# Page Write Buffer with Wrapping Pointer

This block sits between a serial-bus front end and a byte-wide storage array. It gathers the data bytes of one write transaction into a small page buffer and holds them there. A word address load sets the page, taken from the upper address bits, and the starting entry, taken from the low bits. Each byte strobe that follows fills the entry under the pointer and then moves only the low bits of the pointer. The pointer therefore circles inside one page, and a long burst overwrites bytes it has already captured.

Nothing goes to the array while bytes are arriving. A STOP pulse starts the internal write cycle. The block scans every buffer entry once, in ascending order, and issues an array write only for entries that were filled. It then keeps `busy` high for a programmable number of extra cycles, and the front end uses that signal to withhold acknowledges. A START that arrives in place of STOP abandons the buffered bytes, and so does a new word address.

Top module: `page_write_buffer`

## Requirements
- R1: After reset `busy` and `mem_we` are low, the buffer holds no bytes and a STOP that follows starts no write cycle.
- R2: With `busy` low, a `byte_valid` pulse stores `byte_in` at the entry selected by the pointer and then increments only the pointer's low 3 bits (the page offset). The entry is address bits [2:0] and the page is bits [7:3].
- R3: Every array write in a commit carries, in `mem_addr[7:3]`, the page taken from the most recent `addr_load`.
- R4: When more than 8 bytes arrive before STOP, the pointer wraps from offset 7 to 0 and a later byte replaces the earlier byte at the same offset.
- R5: The array is not written before STOP. In the 8 cycles that follow the STOP cycle, offset k is presented in cycle k, and `mem_we` is high only for offsets that received a byte.
- R6: A single byte after an address load, followed by STOP, writes exactly that one location.
- R7: `busy` rises in the cycle after an accepted STOP and stays high for 8 + `BUSY_CYCLES` cycles. While `busy` is high, `byte_valid`, `addr_load`, `stop_pulse` and `start_pulse` have no effect.
- R8: The record of filled entries clears when a commit completes and when a new address is loaded. Bytes taken before a reload are never written.
- R9: A `start_pulse` with `busy` low discards all buffered bytes, so a later STOP writes nothing from them.
- R10: A STOP that arrives while no entry holds a byte leaves `busy` low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the word address from `addr_in` |
| addr_in | input | ADDR_W | Word address (page in the upper bits, offset in the low bits) |
| byte_valid | input | 1 | One data byte is present on `byte_in` |
| byte_in | input | DATA_W | Data byte |
| stop_pulse | input | 1 | STOP seen on the bus; commit the buffer |
| start_pulse | input | 1 | START seen before STOP; discard the buffer |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
A wrong pointer, page or fill mask is invisible while bytes are being collected. It shows up in the first commit after it occurs, as a write to the wrong location, a write that should not happen, or a write that is missing. The bench compares `busy`, `mem_we`, `mem_addr` and `mem_wdata` against its model in every cycle, so such a fault is reported within 8 cycles of the STOP. A fault in the hold count appears when `busy` falls, no later than 8 + `BUSY_CYCLES` cycles after the STOP. After each scenario the bench also compares the whole array image, which catches writes that leaked outside a commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        PW_IDLE   = 2'd0,
        PW_COMMIT = 2'd1,
        PW_HOLD   = 2'd2
    } pw_state_e;

endpackage

// File: rtl/pwb_store.sv
// Page buffer entries with a per-entry fill flag.
module pwb_store #(
    parameter int DATA_W  = 8,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ENTRIES-1:0] fill
);

    logic [DATA_W-1:0] data_arr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        typedef struct packed {
            logic              valid;
            logic [DATA_W-1:0] data;
        } ent_t;

        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (clr) begin
                ent_d.valid = 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                ent_d.valid = 1'b1;
                ent_d.data  = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign data_arr[e] = ent_q.data;
        assign fill[e]     = ent_q.valid;
    end

    assign rd_data  = data_arr[rd_idx];
    assign rd_valid = fill[rd_idx];

endmodule

// File: rtl/pwb_timer.sv
// Counts the extra busy cycles that follow the array scan.
module pwb_timer #(
    parameter int CYCLES = 20,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = '0;
        end else if (tmr_q.active) begin
            if (tmr_q.cnt == CNT_W'(CYCLES - 1)) tmr_d.active = 1'b0;
            else                                  tmr_d.cnt    = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.active && (tmr_q.cnt == CNT_W'(CYCLES - 1));

endmodule

// File: rtl/page_write_buffer.sv
// Collects one transaction's bytes per page; commits them on STOP.
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 8,   // power of two
    parameter int BUSY_CYCLES = 20,  // at least 1
    localparam int PTR_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_pulse,
    input  logic              start_pulse,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef struct packed {
        pw_state_e         state;
        logic [PAGE_W-1:0] page;
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  scan;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  store_wr;
    logic                  store_clr;
    logic                  tmr_start;
    logic                  tmr_done;
    logic [DATA_W-1:0]     rd_data;
    logic                  rd_valid;
    logic [PAGE_BYTES-1:0] fill;

    always_comb begin
        ctl_d     = ctl_q;
        store_wr  = 1'b0;
        store_clr = 1'b0;
        tmr_start = 1'b0;
        unique case (ctl_q.state)
            PW_IDLE: begin
                if (start_pulse) begin
                    store_clr = 1'b1;
                end else if (stop_pulse) begin
                    if (|fill) begin
                        ctl_d.state = PW_COMMIT;
                        ctl_d.scan  = '0;
                    end
                end else if (addr_load) begin
                    ctl_d.page = addr_in[ADDR_W-1:PTR_W];
                    ctl_d.ptr  = addr_in[PTR_W-1:0];
                    store_clr  = 1'b1;
                end else if (byte_valid) begin
                    store_wr  = 1'b1;
                    ctl_d.ptr = ctl_q.ptr + 1'b1;
                end
            end
            PW_COMMIT: begin
                ctl_d.scan = ctl_q.scan + 1'b1;
                if (ctl_q.scan == PTR_W'(PAGE_BYTES - 1)) begin
                    ctl_d.state = PW_HOLD;
                    tmr_start   = 1'b1;
                    store_clr   = 1'b1;
                end
            end
            PW_HOLD: begin
                if (tmr_done) ctl_d.state = PW_IDLE;
            end
            default: ctl_d.state = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: PW_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    pwb_store #(
        .DATA_W  (DATA_W),
        .ENTRIES (PAGE_BYTES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_wr),
        .wr_idx   (ctl_q.ptr),
        .wr_data  (byte_in),
        .clr      (store_clr),
        .rd_idx   (ctl_q.scan),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .fill     (fill)
    );

    pwb_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    assign busy      = (ctl_q.state != PW_IDLE);
    assign mem_we    = (ctl_q.state == PW_COMMIT) && rd_valid;
    assign mem_addr  = {ctl_q.page, ctl_q.scan};
    assign mem_wdata = rd_data;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 8,
    localparam int PTR_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_pulse,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    // R5: array writes happen only inside a write cycle
    a_r5_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R5: offsets are written in ascending order
    a_r5_ascending_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[PTR_W-1:0] > $past(mem_addr[PTR_W-1:0])));

    // R3: the page bits do not change within a commit
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:PTR_W] == $past(mem_addr[ADDR_W-1:PTR_W])));

    // R7: a write cycle begins only after STOP
    a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse));

    // R7: busy lasts longer than a single cycle
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

endmodule

bind page_write_buffer pwb_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
) u_pwb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_pulse (stop_pulse),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr)
);

// File: tb/test_page_write_buffer.sv
`timescale 1ns/1ps
module test_page_write_buffer;

    localparam int BC  = 20;
    localparam int TOT = 8 + BC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld = 1'b0, bv = 1'b0, sp = 1'b0, st = 1'b0;
    logic [7:0] ad = '0, bd = '0;
    logic       busy, mem_we;
    logic [7:0] mem_addr, mem_wdata;

    always #4 clk = ~clk;

    page_write_buffer #(.BUSY_CYCLES(BC)) i_page_write_buffer (
        .clk(clk), .rst_n(rst_n), .addr_load(ld), .addr_in(ad),
        .byte_valid(bv), .byte_in(bd), .stop_pulse(sp), .start_pulse(st),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // array model driven by the block
    logic [7:0] ram     [256];
    logic [7:0] exp_ram [256];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    // behavioural reference
    int         m_busy = 0;
    int         m_page = 0;
    int         m_ptr  = 0;
    logic [7:0] m_buf [8];
    logic [7:0] m_mask = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_mask = '0; m_page = 0; m_ptr = 0;
        end else if (m_busy > 0) begin
            if (TOT - m_busy == 7) m_mask = '0;
            m_busy--;
        end else if (st) begin
            m_mask = '0;
        end else if (sp) begin
            if (m_mask != 0) begin
                m_busy = TOT;
                for (int i = 0; i < 8; i++)
                    if (m_mask[i]) exp_ram[m_page*8 + i] = m_buf[i];
            end
        end else if (ld) begin
            m_page = ad >> 3; m_ptr = ad & 7; m_mask = '0;
        end else if (bv) begin
            m_buf[m_ptr] = bd; m_mask[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8;
        end
    end

    // per-cycle comparison (R5, R7, R3, R10)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int  k;
            bit  e_busy, e_we;
            k      = TOT - m_busy;
            e_busy = (m_busy > 0);
            e_we   = e_busy && (k < 8) && m_mask[k];
            checks++;
            if (busy !== e_busy || mem_we !== e_we ||
                (e_we && (mem_addr !== 8'(m_page*8 + k) || mem_wdata !== m_buf[k]))) begin
                fails++;
                $display("FAIL R5/R7 cycle: busy=%0b we=%0b addr=%0h data=%0h expected busy=%0b we=%0b addr=%0h data=%0h",
                         busy, mem_we, mem_addr, mem_wdata, e_busy, e_we,
                         8'(m_page*8 + k), e_we ? m_buf[k] : 8'h0);
            end
        end
    end

    task automatic do_load(input logic [7:0] a);
        @(negedge clk); ld = 1'b1; ad = a;
        @(negedge clk); ld = 1'b0;
    endtask
    task automatic do_byte(input logic [7:0] d);
        @(negedge clk); bv = 1'b1; bd = d;
        @(negedge clk); bv = 1'b0;
    endtask
    task automatic do_stop();
        @(negedge clk); sp = 1'b1;
        @(negedge clk); sp = 1'b0;
    endtask
    task automatic do_start();
        @(negedge clk); st = 1'b1;
        @(negedge clk); st = 1'b0;
    endtask
    task automatic settle();
        repeat (TOT + 3) @(negedge clk);
    endtask
    task automatic check_ram(input string tag);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (ram[i] !== exp_ram[i] && bad < 0) bad = i;
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: ram[%0h]=%0h expected %0h", tag, bad, ram[bad], exp_ram[bad]);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; exp_ram[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (busy !== 1'b0 || mem_we !== 1'b0) begin
            fails++;
            $display("FAIL R1: busy=%0b we=%0b expected 0 0", busy, mem_we);
        end
        rst_n = 1'b1;
        @(negedge clk);
        do_stop(); settle();                                // R1, R10: empty buffer
        check_ram("R1 stop after reset");

        do_load(8'h25); do_byte(8'hA1); do_stop(); settle(); // R6 single byte
        check_ram("R6 single byte write");

        do_load(8'h40);                                     // R2 full page
        for (int i = 0; i < 8; i++) do_byte(8'h10 + 8'(i));
        check_ram("R5 no write before stop");
        do_stop(); settle();
        check_ram("R2 full page");

        do_load(8'h7E);                                     // R3 offset 6, wraps to 0,1
        do_byte(8'hC6); do_byte(8'hC7); do_byte(8'hC0); do_byte(8'hC1);
        do_stop(); settle();
        check_ram("R3 page bits fixed");

        do_load(8'h88);                                     // R4 eleven bytes
        for (int i = 0; i < 11; i++) do_byte(8'h50 + 8'(i));
        do_stop(); settle();
        check_ram("R4 wrap overwrite");

        do_load(8'h90); do_byte(8'hDD); do_byte(8'hDE);     // R9 discard
        do_start(); do_stop(); settle();
        check_ram("R9 start discards");

        do_load(8'hA0); do_byte(8'h11); do_byte(8'h12);     // R8 reload clears
        do_load(8'hB3); do_byte(8'h33);
        do_stop(); settle();
        check_ram("R8 reload clears");

        do_load(8'hC0); do_byte(8'h77); do_stop();          // R7 inputs ignored while busy
        do_byte(8'hEE); do_load(8'hD5); do_stop(); do_start();
        settle();
        do_stop(); settle();                                // R10 nothing buffered
        check_ram("R7 busy ignores inputs");
        do_byte(8'h99); do_stop(); settle();                // pointer from 0xC0 load: C1
        check_ram("R7 pointer kept across busy");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule